// File: doc/BRIEF.md
# Query and Identifier Response Lane Builder

This block forms the read word that a bank of identical parallel flash devices returns when the bank is in query mode or in identifier mode. A bank is described by four width codes, each the base-2 log of a byte count. They give the bank width, the width at which each device is wired, the widest width the devices support, and the width of the read. From these codes and the bus byte offset, the block computes a table index or an identifier index. It then fetches the byte or the identifier word for one device, repeats it across the device lanes of the bank, and stacks several bank-sized slices when the read is wider than the bank.

The command sequencer sits outside this block and raises `rd_stb` when a read in one of these modes is issued. The block registers the answer on that clock edge. A two-state controller (IDLE, SHOW) then flags the answer on `rsp_valid` for one cycle. The transitions are: IDLE to SHOW on a strobe, SHOW to SHOW on a further strobe, SHOW to IDLE when no strobe arrives, and IDLE to IDLE otherwise. The table contents are computed inside the block.

Top module: `qrl_lane_builder`

## Requirements
- R1: While `rst_n` is low, and on release of reset, `rsp_valid` is 0 and `rsp_data` is 0.
- R2: A strobe sampled on a rising edge loads `rsp_data` on that edge, and `rsp_valid` is 1 for the following cycle. Without a strobe, `rsp_valid` is 0 and `rsp_data` holds its value.
- R3: The query index is the slice offset shifted right by `bank_lg + maxdev_lg - dev_lg`. Table byte 0x10 is 0x51, 0x11 is 0x52, 0x12 is 0x59 and 0x2C is 0x01. Every other index below 0x52 holds index XOR 0x5A.
- R4: A query index of 0x52 or above yields a zero device byte.
- R5: When the device width equals the maximum device width, a query device lane is the table byte zero-extended to the device width.
- R6: When `dev_lg` is 0 and `maxdev_lg` is above 0, the table byte fills every byte of the bank slice.
- R7: The whole result is zero in any of these cases: a device narrower than its maximum but wider than one byte, a device wider than the bank, a device wider than its maximum, or any width code equal to 3.
- R8: The device lane, `dev_lg` bytes wide, is copied into every device lane of the bank slice.
- R9: Identifier mode (`id_mode` = 1) uses bits 7:0 of the index. Value 0 selects `mfr_id`, value 1 selects `part_id`, and any other value gives zero. The identifier is zero-extended or truncated to the device width.
- R10: When `rd_lg` is above `bank_lg`, the result holds 2^(`rd_lg`-`bank_lg`) slices. Slice j uses offset `byte_off` + j·bankbytes², taken modulo 2^OFF_W, and sits at byte j·bankbytes.
- R11: Result bytes above both the read width and the bank width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read request in query or identifier mode |
| id_mode | input | 1 | 0 selects a query read, 1 selects an identifier read |
| byte_off | input | OFF_W | Bus byte offset of the read |
| bank_lg | input | 2 | log2 of the bank width in bytes |
| dev_lg | input | 2 | log2 of the wired device width in bytes |
| maxdev_lg | input | 2 | log2 of the maximum device width in bytes |
| rd_lg | input | 2 | log2 of the read width in bytes |
| mfr_id | input | 16 | Manufacturer identifier word |
| part_id | input | 16 | Device identifier word |
| rsp_valid | output | 1 | Result valid, one cycle after a strobe |
| rsp_data | output | 32 | Result word |

## Verification
Every legal combination of bank, device, maximum and read width is tried in both modes. Each combination is tried at offsets chosen so that a wrong shift amount lands on a different table byte. The offsets reach the signature bytes, the region-count byte, the out-of-range index and index values that alias only through bit 8. A hand-worked vector table separates zero-padding from byte repetition, per-lane replication from a single copy, and narrow reads from wide multi-slice reads. Directed cases cover the unsupported width codes, the strobe timing and the hold of the result.

// File: rtl/qrl_pkg.sv
package qrl_pkg;
    localparam int TAB_LEN    = 82;
    localparam int BUS_BYTES  = 4;
    localparam int DATA_W     = 8 * BUS_BYTES;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } qrl_state_t;

    function automatic logic [7:0] qrl_tab_byte(input logic [6:0] idx);
        logic [7:0] b;
        unique case (idx)
            7'h10:   b = 8'h51;
            7'h11:   b = 8'h52;
            7'h12:   b = 8'h59;
            7'h2C:   b = 8'h01;
            default: b = {1'b0, idx} ^ 8'h5A;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/qrl_table_rom.sv
module qrl_table_rom
    import qrl_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] idx,
    output logic [7:0]       tab_byte
);
    logic in_range;

    always_comb begin
        in_range = (idx < OFF_W'(TAB_LEN));
        tab_byte = in_range ? qrl_tab_byte(idx[6:0]) : 8'h00;
    end
endmodule

// File: rtl/qrl_slice_unit.sv
module qrl_slice_unit
    import qrl_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0]  slice_off,
    input  logic              id_mode,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        maxdev_lg,
    input  logic [15:0]       mfr_id,
    input  logic [15:0]       part_id,
    output logic [DATA_W-1:0] slice_word
);
    logic [2:0]        shamt;
    logic [OFF_W-1:0]  idx;
    logic [7:0]        tab_byte;
    logic [15:0]       id_word;
    logic [DATA_W-1:0] lane;
    logic [DATA_W-1:0] repl;
    logic [2:0]        bank_bytes;
    logic [2:0]        dev_mask;
    logic              cfg_ok;

    qrl_table_rom #(.OFF_W(OFF_W)) u_rom (
        .idx      (idx),
        .tab_byte (tab_byte)
    );

    always_comb begin
        shamt      = {1'b0, bank_lg} + {1'b0, maxdev_lg} - {1'b0, dev_lg};
        idx        = slice_off >> shamt;
        bank_bytes = 3'd1 << bank_lg;
        dev_mask   = (3'd1 << dev_lg) - 3'd1;
        cfg_ok     = (bank_lg != 2'd3) && (dev_lg != 2'd3) && (maxdev_lg != 2'd3)
                  && (dev_lg <= bank_lg) && (dev_lg <= maxdev_lg)
                  && !((dev_lg < maxdev_lg) && (dev_lg != 2'd0));
        unique case (idx[7:0])
            8'h00:   id_word = mfr_id;
            8'h01:   id_word = part_id;
            default: id_word = 16'h0000;
        endcase
        lane = id_mode ? {16'h0000, id_word} : {24'h000000, tab_byte};
    end

    for (genvar K = 0; K < BUS_BYTES; K++) begin : g_byte
        always_comb begin
            if (3'(K) < bank_bytes)
                repl[8*K +: 8] = lane[8 * (K & int'(dev_mask)) +: 8];
            else
                repl[8*K +: 8] = 8'h00;
        end
    end

    assign slice_word = cfg_ok ? repl : '0;
endmodule

// File: rtl/qrl_lane_builder.sv
module qrl_lane_builder
    import qrl_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              id_mode,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        maxdev_lg,
    input  logic [1:0]        rd_lg,
    input  logic [15:0]       mfr_id,
    input  logic [15:0]       part_id,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int SLICES = BUS_BYTES;

    qrl_state_t        state_q, state_d;
    logic [DATA_W-1:0] slice_word [SLICES];
    logic [DATA_W-1:0] placed     [SLICES];
    logic [DATA_W-1:0] merged;

    for (genvar J = 0; J < SLICES; J++) begin : g_slice
        logic [OFF_W-1:0] step;
        logic [6:0]       bitpos;
        logic             en;

        always_comb begin
            step   = OFF_W'(J) << {bank_lg, 1'b0};
            bitpos = 7'(J) << ({1'b0, bank_lg} + 3'd3);
            en     = (J == 0) ||
                     ((rd_lg > bank_lg) && (3'(J) < (3'd1 << (rd_lg - bank_lg))));
        end

        qrl_slice_unit #(.OFF_W(OFF_W)) u_slice (
            .slice_off  (byte_off + step),
            .id_mode    (id_mode),
            .bank_lg    (bank_lg),
            .dev_lg     (dev_lg),
            .maxdev_lg  (maxdev_lg),
            .mfr_id     (mfr_id),
            .part_id    (part_id),
            .slice_word (slice_word[J])
        );

        assign placed[J] = en ? (slice_word[J] << bitpos) : '0;
    end

    always_comb begin
        merged = '0;
        for (int j = 0; j < SLICES; j++) begin
            merged = merged | placed[j];
        end
        if (rd_lg == 2'd3) merged = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_stb ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = rd_stb ? ST_SHOW : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_data <= '0;
        else if (rd_stb) rsp_data <= merged;
    end

    assign rsp_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/qrl_lane_builder_chk.sv
module qrl_lane_builder_chk
    import qrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              id_mode,
    input logic [1:0]        bank_lg,
    input logic [1:0]        dev_lg,
    input logic [1:0]        rd_lg,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data
);
    assert_valid_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rsp_valid);

    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rsp_valid);

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rsp_data));

    assert_dev_wider_than_bank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (dev_lg > bank_lg)) |=> (rsp_data == '0));

    assert_narrow_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (rd_lg == 2'd0) && (bank_lg == 2'd0)) |=> (rsp_data[31:8] == 24'h0));

    assert_byte_lanes_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && id_mode && (dev_lg == 2'd0) && (bank_lg == 2'd2) && (rd_lg == 2'd2))
        |=> ((rsp_data[31:24] == rsp_data[7:0]) && (rsp_data[15:8] == rsp_data[7:0])));
endmodule

bind qrl_lane_builder qrl_lane_builder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .id_mode   (id_mode),
    .bank_lg   (bank_lg),
    .dev_lg    (dev_lg),
    .rd_lg     (rd_lg),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/qrl_lane_builder_bench.sv
module qrl_lane_builder_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MFR = 16'hA1B2;
    localparam logic [15:0] PRT = 16'hC3D4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        id_mode = 1'b0;
    logic [15:0] byte_off = '0;
    logic [1:0]  bank_lg = '0, dev_lg = '0, maxdev_lg = '0, rd_lg = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qrl_lane_builder #(.OFF_W(16)) u_qrl_lane_builder (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .id_mode(id_mode),
        .byte_off(byte_off), .bank_lg(bank_lg), .dev_lg(dev_lg),
        .maxdev_lg(maxdev_lg), .rd_lg(rd_lg), .mfr_id(MFR), .part_id(PRT),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // {mode, bank, dev, max, rd, offset, expected}
    localparam logic [56:0] VEC [14] = '{
        {1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00000051}, // R3 signature byte
        {1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0022, 32'h00000052}, // R5 zero-extended lane
        {1'b0, 2'd2, 2'd0, 2'd1, 2'd2, 16'h0080, 32'h51515151}, // R6 byte repetition
        {1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 16'h0058, 32'h004C004C}, // R8 lane replication
        {1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 16'h0010, 32'h49595251}, // R10 four slices
        {1'b0, 2'd1, 2'd0, 2'd0, 2'd2, 16'h0020, 32'h59595151}, // R10 two slices
        {1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0052, 32'h00000000}, // R4 out of range
        {1'b0, 2'd2, 2'd1, 2'd2, 2'd2, 16'h0000, 32'h00000000}, // R7 x16 on x32 part
        {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 32'h000000B2}, // R9 truncated mfr
        {1'b1, 2'd2, 2'd1, 2'd1, 2'd2, 16'h0004, 32'hC3D4C3D4}, // R9 part id replicated
        {1'b1, 2'd1, 2'd1, 2'd1, 2'd2, 16'h0000, 32'h0000A1B2}, // R9 index 2 is zero
        {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0100, 32'h000000B2}, // R9 low 8 bits only
        {1'b0, 2'd2, 2'd2, 2'd2, 2'd0, 16'h00B0, 32'h00000001}, // R11 region count byte
        {1'b0, 2'd1, 2'd0, 2'd1, 2'd0, 16'h0040, 32'h00005151}  // R11 read below bank
    };

    localparam logic [15:0] OFFS [8] = '{16'h0000, 16'h0004, 16'h0040, 16'h0044,
                                          16'h00B0, 16'h0148, 16'h0290, 16'h0402};

    function automatic logic [7:0] tb_tab(input int i);
        if (i >= 82) return 8'h00;
        if (i == 16) return 8'h51;
        if (i == 17) return 8'h52;
        if (i == 18) return 8'h59;
        if (i == 44) return 8'h01;
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [31:0] ref_word(input bit md, input int lb, input int ld,
                                             input int lm, input int lr, input int off);
        logic [31:0] r = '0;
        int bw = 1 << lb, dw = 1 << ld, ns, o, ix;
        logic [7:0] lane [4];
        logic [15:0] idv;
        if (lb > 2 || ld > 2 || lm > 2 || lr > 2 || ld > lb || ld > lm || (ld < lm && ld != 0))
            return '0;
        ns = (lr > lb) ? (1 << (lr - lb)) : 1;
        for (int j = 0; j < ns; j++) begin
            o  = (off + j * bw * bw) % 65536;
            ix = o >> (lb + lm - ld);
            idv = ((ix % 256) == 0) ? MFR : (((ix % 256) == 1) ? PRT : 16'h0);
            for (int b = 0; b < 4; b++) begin
                if (md) lane[b] = (b < 2) ? idv[8*b +: 8] : 8'h00;
                else    lane[b] = (b == 0) ? tb_tab(ix) : 8'h00;
            end
            for (int k = 0; k < bw; k++) r[8*(j*bw + k) +: 8] = lane[k % dw];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_read(input bit md, input int lb, input int ld, input int lm,
                           input int lr, input int off);
        @(negedge clk);
        id_mode = md; bank_lg = 2'(lb); dev_lg = 2'(ld); maxdev_lg = 2'(lm);
        rd_lg = 2'(lr); byte_off = 16'(off); rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        #(CLK_PERIOD * 2);
        check("R1 valid in reset", 32'(rsp_valid), 32'd0);
        check("R1 data in reset", rsp_data, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 32'(rsp_valid), 32'd0);

        for (int v = 0; v < 14; v++) begin
            do_read(VEC[v][56], int'(VEC[v][55:54]), int'(VEC[v][53:52]),
                    int'(VEC[v][51:50]), int'(VEC[v][49:48]), int'(VEC[v][47:32]));
            check($sformatf("vector %0d R2 valid", v), 32'(rsp_valid), 32'd1);
            check($sformatf("vector %0d R3-R11 data", v), rsp_data, VEC[v][31:0]);
        end

        for (int lb = 0; lb < 3; lb++)
            for (int ld = 0; ld <= lb; ld++)
                for (int lm = ld; lm < 3; lm++)
                    for (int lr = 0; lr < 3; lr++)
                        for (int md = 0; md < 2; md++)
                            for (int k = 0; k < 8; k++) begin
                                do_read(md[0], lb, ld, lm, lr, int'(OFFS[k]));
                                check($sformatf("%s R8 b%0d d%0d m%0d r%0d off %h",
                                      (lr > lb) ? "R10" : (md ? "R9" : "R3"),
                                      lb, ld, lm, lr, OFFS[k]),
                                      rsp_data, ref_word(md[0], lb, ld, lm, lr, int'(OFFS[k])));
                            end

        // R2: no strobe -> valid low and data held
        held = rsp_data;
        @(negedge clk);
        byte_off = 16'h0011; id_mode = 1'b0;
        @(negedge clk);
        check("R2 valid without strobe", 32'(rsp_valid), 32'd0);
        check("R2 data held", rsp_data, held);

        // R7: width code 3 and device wider than bank
        do_read(1'b0, 0, 0, 3, 0, 16'h0010);
        check("R7 max code 3", rsp_data, 32'd0);
        do_read(1'b1, 2, 2, 2, 3, 16'h0000);
        check("R7 read code 3", rsp_data, 32'd0);
        do_read(1'b1, 0, 1, 1, 0, 16'h0000);
        check("R7 device wider than bank", rsp_data, 32'd0);

        // R2: back-to-back strobes keep valid high
        @(negedge clk);
        id_mode = 1'b1; bank_lg = 2'd0; dev_lg = 2'd0; maxdev_lg = 2'd0; rd_lg = 2'd0;
        byte_off = 16'h0000; rd_stb = 1'b1;
        @(negedge clk);
        check("R2 first of pair", rsp_data, 32'h000000B2);
        byte_off = 16'h0001;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R2 second of pair valid", 32'(rsp_valid), 32'd1);
        check("R2 second of pair data", rsp_data, 32'h000000D4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule